// File: doc/BRIEF.md
# Clock Source Select Control Register

An 8-bit, bus-mapped control register that picks the system clock source (crystal, slow clock or PLL) and the module clock source. It also holds the limp-home interrupt enable and the bit that sets how the chip reacts to a lost reference clock. Software writes it through a plain select/write-strobe port and reads it back on a combinational read-data bus.

The values held in the register and the selects driven to the clock muxes can differ. While limp-home mode is active the effective selects are overridden, but reads still return the stored values. A missing PLL supply pins two bits to fixed values, and that forcing beats a bus write in the same cycle. The loss-of-clock policy bit can be written only once after reset in normal mode, and any number of times in special mode. The muxes, the clock monitor, the PLL and the interrupt logic are outside this block.

Top module: `clk_src_ctl`

## Requirements
- R1: After reset, with the supply-absent flag low, read data is 0x00, `sys_sel_o` is 00, and `mod_sel_o`, `limp_irq_en_o` and `no_limp_o` are 0.
- R2: Field layout of read and write data: bit 7 is the limp-home interrupt enable, bit 6 is no-limp-home, bit 5 is PLL select, bit 4 is slow select and bit 2 is module-clock select. Bits 3, 1 and 0 always read 0 and ignore writes. A write takes effect on the clock edge where it is sampled and is visible on `rdata_o` right after that edge.
- R3: `sys_sel_o` encodes the system clock as 00 = crystal, 01 = slow, 10 = PLL. When the PLL bit is 1 it gives 10 whatever the slow bit holds.
- R4: A write of 1 to bit 5 while `pll_on_i` is 0 leaves the PLL bit at 0.
- R5: While `limp_act_i` is 1, `sys_sel_o` is 10 and `mod_sel_o` is 0, and `rdata_o` still returns the stored bits.
- R6: While `pll_sup_absent_i` is 1, bit 5 reads 0 and bit 6 reads 1, both at once and in the stored state. This forcing wins over a write in the same cycle, and the forced values stay stored after the flag drops.
- R7: With `special_i` low, only the first register write after reset can change bit 6. Any write with the strobe asserted uses up that single chance, even one that leaves bit 6 unchanged.
- R8: With `special_i` high, bit 6 follows every write, and such writes do not use up the single normal-mode chance.
- R9: Bits 7, 4 and 2 follow every write. A write needs both `sel_i` and `wr_i` high; a strobe without select changes nothing.
- R10: `limp_irq_en_o` and `no_limp_o` always match read-data bits 7 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_i | input | 1 | Address match for this register |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data showing the stored bits |
| pll_on_i | input | 1 | PLL is running |
| pll_sup_absent_i | input | 1 | PLL supply is missing |
| special_i | input | 1 | Special operating mode |
| limp_act_i | input | 1 | Limp-home mode is active |
| sys_sel_o | output | 2 | Effective system clock select (00 crystal, 01 slow, 10 PLL) |
| mod_sel_o | output | 1 | Effective module clock select (1 = slow-derived) |
| limp_irq_en_o | output | 1 | Limp-home interrupt enable |
| no_limp_o | output | 1 | 1 = reset on clock loss, 0 = enter limp-home |

## Verification
Directed sequences first write all-ones with the PLL off. This separates the gated PLL bit from the freely written bits and the bits that are not implemented. The bench then repeats writes in normal mode, then in special mode, so that a write-once lock that never engages or never releases shows up. Limp-home and supply-absent are raised on top of known stored values: limp-home must change the outputs but not the read data, while supply-absent must change both and also win over a same-cycle write. A long stretch of random bus traffic with random mode, PLL and override flags is then checked every clock against a behavioural model, covering the flag combinations the directed cases do not reach.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  localparam int REG_W  = 8;
  localparam int B_IE   = 7;
  localparam int B_NOLH = 6;
  localparam int B_PLL  = 5;
  localparam int B_SLOW = 4;
  localparam int B_MCS  = 2;
  localparam logic [REG_W-1:0] USED_MASK =
    REG_W'((1 << B_IE) | (1 << B_NOLH) | (1 << B_PLL) | (1 << B_SLOW) | (1 << B_MCS));

  typedef enum logic [1:0] {
    SYS_XTAL = 2'b00,
    SYS_SLOW = 2'b01,
    SYS_PLL  = 2'b10
  } sys_src_e;

  typedef struct packed {
    logic irq_en;
    logic no_limp;
    logic pll_sel;
    logic slow_sel;
    logic mod_sel;
  } ctl_fields_t;
endpackage

// File: rtl/clk_src_rst_sync.sv
module clk_src_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_nxt = 1'b1;
    end else begin : g_many
      assign chain_nxt = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_n_sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/clk_src_regs.sv
module clk_src_regs
  import clk_src_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             pll_on_i,
  input  logic             sup_absent_i,
  input  logic             special_i,
  output ctl_fields_t      view_o,
  output logic [REG_W-1:0] rdata_o
);
  ctl_fields_t cur_q, cur_nxt;
  logic        once_q, once_nxt;
  logic        wr_hit;
  logic        upd_en;

  logic unused_wbits;
  assign unused_wbits = ^(wdata_i & ~USED_MASK);

  assign wr_hit = sel_i & wr_i;
  assign upd_en = wr_hit | sup_absent_i;

  always_comb begin
    cur_nxt  = cur_q;
    once_nxt = once_q;
    if (wr_hit) begin
      cur_nxt.irq_en   = wdata_i[B_IE];
      cur_nxt.slow_sel = wdata_i[B_SLOW];
      cur_nxt.mod_sel  = wdata_i[B_MCS];
      cur_nxt.pll_sel  = wdata_i[B_PLL] & pll_on_i;
      if (special_i || !once_q) cur_nxt.no_limp = wdata_i[B_NOLH];
      if (!special_i) once_nxt = 1'b1;
    end
    if (sup_absent_i) begin
      cur_nxt.pll_sel = 1'b0;
      cur_nxt.no_limp = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      once_q <= 1'b0;
    end else if (upd_en) begin
      cur_q  <= cur_nxt;
      once_q <= once_nxt;
    end
  end

  always_comb begin
    view_o = cur_q;
    if (sup_absent_i) begin
      view_o.pll_sel = 1'b0;
      view_o.no_limp = 1'b1;
    end
  end

  always_comb begin
    rdata_o         = '0;
    rdata_o[B_IE]   = view_o.irq_en;
    rdata_o[B_NOLH] = view_o.no_limp;
    rdata_o[B_PLL]  = view_o.pll_sel;
    rdata_o[B_SLOW] = view_o.slow_sel;
    rdata_o[B_MCS]  = view_o.mod_sel;
  end

  // R4
  pll_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && wr_i && wdata_i[B_PLL] && !pll_on_i) |=> !cur_q.pll_sel);

  // R7
  once_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (once_q && !special_i && sel_i && wr_i && !sup_absent_i) |=> $stable(cur_q.no_limp));

  // R6
  absent_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_absent_i |-> (rdata_o[B_NOLH] && !rdata_o[B_PLL]));

  // R2
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o & ~USED_MASK) == '0);
endmodule

// File: rtl/clk_src_eff.sv
module clk_src_eff
  import clk_src_pkg::*;
(
  input  ctl_fields_t view_i,
  input  logic        limp_i,
  output logic [1:0]  sys_sel_o,
  output logic        mod_sel_o
);
  logic pll_eff;

  assign pll_eff = limp_i | view_i.pll_sel;

  always_comb begin
    if (pll_eff)              sys_sel_o = SYS_PLL;
    else if (view_i.slow_sel) sys_sel_o = SYS_SLOW;
    else                      sys_sel_o = SYS_XTAL;
  end

  assign mod_sel_o = view_i.mod_sel & ~limp_i;
endmodule

// File: rtl/clk_src_ctl.sv
module clk_src_ctl
  import clk_src_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             pll_on_i,
  input  logic             pll_sup_absent_i,
  input  logic             special_i,
  input  logic             limp_act_i,
  output logic [1:0]       sys_sel_o,
  output logic             mod_sel_o,
  output logic             limp_irq_en_o,
  output logic             no_limp_o
);
  logic        rst_n_s;
  ctl_fields_t view;

  clk_src_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  clk_src_regs i_regs (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .sel_i        (sel_i),
    .wr_i         (wr_i),
    .wdata_i      (wdata_i),
    .pll_on_i     (pll_on_i),
    .sup_absent_i (pll_sup_absent_i),
    .special_i    (special_i),
    .view_o       (view),
    .rdata_o      (rdata_o)
  );

  clk_src_eff i_eff (
    .view_i    (view),
    .limp_i    (limp_act_i),
    .sys_sel_o (sys_sel_o),
    .mod_sel_o (mod_sel_o)
  );

  assign limp_irq_en_o = view.irq_en;
  assign no_limp_o     = view.no_limp;

  // R5
  limp_override_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    limp_act_i |-> (sys_sel_o == SYS_PLL && !mod_sel_o));

  // R3
  pll_priority_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rdata_o[B_PLL] |-> (sys_sel_o == SYS_PLL));

  // R10
  policy_out_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (no_limp_o == rdata_o[B_NOLH]) && (limp_irq_en_o == rdata_o[B_IE]));
endmodule

// File: tb/test_clk_src_ctl.sv
module test_clk_src_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       pll_on_i = 1'b0, pll_sup_absent_i = 1'b0, special_i = 1'b0, limp_act_i = 1'b0;
  logic [1:0] sys_sel_o;
  logic       mod_sel_o, limp_irq_en_o, no_limp_o;

  int checks = 0;
  int failures = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  // behavioural model state
  bit m_ie, m_nolh, m_pll, m_slow, m_mcs, m_once;

  clk_src_ctl i_clk_src_ctl (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .pll_on_i(pll_on_i), .pll_sup_absent_i(pll_sup_absent_i),
    .special_i(special_i), .limp_act_i(limp_act_i), .sys_sel_o(sys_sel_o),
    .mod_sel_o(mod_sel_o), .limp_irq_en_o(limp_irq_en_o), .no_limp_o(no_limp_o)
  );

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_ie, m_nolh, m_pll, m_slow, m_mcs, m_once} = '0;
    end else begin
      if (sel_i && wr_i) begin
        m_ie   = wdata_i[7];
        m_slow = wdata_i[4];
        m_mcs  = wdata_i[2];
        m_pll  = wdata_i[5] && pll_on_i;
        if (special_i || !m_once) m_nolh = wdata_i[6];
        if (!special_i) m_once = 1'b1;
      end
      if (pll_sup_absent_i) begin
        m_pll  = 1'b0;
        m_nolh = 1'b1;
      end
    end
  end

  function automatic logic [7:0] exp_rd();
    bit p, n;
    p = pll_sup_absent_i ? 1'b0 : m_pll;
    n = pll_sup_absent_i ? 1'b1 : m_nolh;
    return {m_ie, n, p, m_slow, 1'b0, m_mcs, 2'b00};
  endfunction

  function automatic logic [1:0] exp_sys();
    logic [7:0] r;
    r = exp_rd();
    if (limp_act_i || r[5]) return 2'b10;
    if (r[4]) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_en) begin
      logic [7:0] r;
      r = exp_rd();
      chk("R2 rdata", rdata_o, r);
      chk("R3 sys_sel", sys_sel_o, exp_sys());
      chk("R5 mod_sel", mod_sel_o, m_mcs && !limp_act_i);
      chk("R10 irq_en", limp_irq_en_o, r[7]);
      chk("R10 no_limp", no_limp_o, r[6]);
    end
  end

  task automatic wr(input logic [7:0] d);
    sel_i = 1'b1; wr_i = 1'b1; wdata_i = d;
    @(negedge clk); #1;
    sel_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk); #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 cmp_en = 1'b1;
    // R1 reset state
    chk("R1 rdata", rdata_o, 8'h00);
    chk("R1 sys_sel", sys_sel_o, 2'b00);
    chk("R1 outs", {mod_sel_o, limp_irq_en_o, no_limp_o}, 3'b000);

    // R4 PLL gated, R2 unused bits, first normal write sets nolh
    wr(8'hFF);
    chk("R4 R2 all-ones", rdata_o, 8'hD4);
    chk("R3 slow", sys_sel_o, 2'b01);

    // R7 second normal write cannot touch bit 6
    wr(8'h00);
    chk("R7 once lock", rdata_o, 8'h40);
    chk("R9 other bits cleared", rdata_o & 8'hB4, 8'h00);

    // R3 PLL priority over slow
    pll_on_i = 1'b1;
    wr(8'h34);
    chk("R3 pll prio rd", rdata_o, 8'h74);
    chk("R3 pll prio", sys_sel_o, 2'b10);

    // R5 limp override
    wr(8'h94);
    chk("R9 ie/mcs", rdata_o, 8'hD4);
    limp_act_i = 1'b1; idle();
    chk("R5 sys forced", sys_sel_o, 2'b10);
    chk("R5 mod forced", mod_sel_o, 1'b0);
    chk("R5 reads latched", rdata_o, 8'hD4);
    limp_act_i = 1'b0; idle();
    chk("R5 release", {sys_sel_o, mod_sel_o}, 3'b011);

    // R9 strobe without select ignored
    wr_i = 1'b1; wdata_i = 8'h00; idle(); wr_i = 1'b0;
    chk("R9 no sel", rdata_o, 8'hD4);

    // R8 special mode
    special_i = 1'b1;
    wr(8'h00);
    chk("R8 special clear", rdata_o, 8'h00);
    wr(8'h40);
    chk("R8 special set", rdata_o, 8'h40);
    wr(8'h00);
    chk("R8 special clear again", no_limp_o, 1'b0);

    // R6 supply absent beats write
    pll_sup_absent_i = 1'b1;
    sel_i = 1'b1; wr_i = 1'b1; wdata_i = 8'h20;
    @(negedge clk); #1;
    sel_i = 1'b0; wr_i = 1'b0;
    chk("R6 forced read", rdata_o, 8'h40);
    chk("R6 sys", sys_sel_o, 2'b00);
    pll_sup_absent_i = 1'b0; idle();
    chk("R6 held after drop", rdata_o, 8'h40);
    special_i = 1'b0;

    // random phase, compared every clock against the model
    for (int i = 0; i < 2000; i++) begin
      sel_i = ($urandom_range(0, 2) != 0);
      wr_i = ($urandom_range(0, 1) != 0);
      wdata_i = 8'($urandom);
      pll_on_i = ($urandom_range(0, 3) != 0);
      pll_sup_absent_i = ($urandom_range(0, 7) == 0);
      special_i = ($urandom_range(0, 3) == 0);
      limp_act_i = ($urandom_range(0, 5) == 0);
      if (i == 1000) begin
        rst_n = 1'b0; #1 rst_n = 1'b1;
        pll_sup_absent_i = 1'b0; sel_i = 1'b0;
        cmp_en = 1'b0;
        repeat (3) idle();
        cmp_en = 1'b1;
      end
      idle();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule